// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a single-cycle internal request bus and an external 16-bit asynchronous static RAM. The RAM has a common data bus and active-low control pins. An accepted request becomes a timed sequence on chip enable, write enable, output enable and the two byte-lane enables. The length of each phase is a parameter counted in system clock cycles: address setup, write strobe width, hold after the strobe and read access time.

Writes keep the output enable high for their whole duration. The controller turns on its own data drivers only once the setup phase is over, and releases them one cycle after the write strobe rises. The address and lane enables do not move while the strobe is low. Reads return the captured word with a one-cycle valid pulse, and lanes that were not requested read back as zero. A request whose byte mask is empty completes without touching the memory. Between accesses the memory is kept in standby, with chip enable and both lane enables high.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While the controller is idle (`req_ready` high), and throughout reset, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are all 1 and `mem_dq_oe` is 0.
- R2: A write with a non-empty mask drives the following, starting the cycle after acceptance. `mem_ce_n` is low. The lane enables follow the mask: mask bit 1 drives `mem_ub_n` low for data bits 15:8, and mask bit 0 drives `mem_lb_n` low for bits 7:0. `mem_addr` is the request address. `mem_we_n` stays high for T_SETUP cycles, then goes low for T_PULSE cycles, then is high again for T_HOLD cycles with chip enable still low. After that the controller returns to idle.
- R3: During any access (`mem_ce_n` low), `mem_addr`, `mem_ub_n` and `mem_lb_n` do not change.
- R4: `mem_oe_n` is high whenever `mem_we_n` is low or `mem_dq_oe` is high.
- R5: `mem_dq_oe` is high exactly during the write strobe and the first cycle after the strobe rises. While it is high, `mem_dq_out` carries the request write data.
- R6: A read with a non-empty mask holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for T_READ cycles, with the lane enables following the mask. `rsp_valid` is high for one cycle, the cycle after the last access cycle. `rsp_rdata` is `mem_dq_in` as it was sampled in the last access cycle, with the unselected lanes forced to zero.
- R7: A request with mask 2'b00 causes no memory activity and leaves `req_ready` high. If it is a read, `rsp_valid` rises in the following cycle with `rsp_rdata` equal to 0.
- R8: `req_ready` is low for the whole of an access. A request presented while `req_ready` is low is not taken.
- R9: A write changes only the selected lanes of the addressed word. A later read returns the merged contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 1 = upper byte, bit 0 = lower byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | 16 | Data read from the memory bus |

## Verification
A wrong phase or a wrong counter value shows up on the memory pins within the access it corrupts. It appears as a setup, strobe or hold length that differs from its parameter, or as an address or lane enable moving while chip enable is low. A lost or extra read capture shows up at the response port as a wrong latency, or as a second valid pulse one cycle later. A stuck lane register, or a wrong mask, leaves a bad lane in memory. That error appears on the next read of the same word, which the bench makes likely by confining random addresses to a few words.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_WSETUP  = 3'd1,
    PH_WPULSE  = 3'd2,
    PH_WHOLD   = 3'd3,
    PH_RACCESS = 3'd4
  } phase_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0]        mask,
  output logic [LANES-1:0]        be_n,
  output logic [LANES*LANE_W-1:0] bit_mask,
  output logic                    any
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_n[i]                      = ~mask[i];
    assign bit_mask[i*LANE_W +: LANE_W] = {LANE_W{mask[i]}};
  end

  assign any = |mask;

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int LANES   = 2,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 2,
  parameter int T_SETUP = 1,
  parameter int T_PULSE = 2,
  parameter int T_HOLD  = 1,
  parameter int T_READ  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be_n,
  input  logic [DATA_W-1:0] req_bits,
  input  logic              req_any,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  phase_t            phase, phase_n;
  logic [DATA_W-1:0] bits_q;
  logic              accept;
  logic              start;
  logic              capture;
  logic              empty_rd;

  assign accept   = req_valid && ready;
  assign start    = (phase == PH_IDLE) && (phase_n != PH_IDLE);
  assign capture  = (phase == PH_RACCESS) && tmr_done;
  assign empty_rd = accept && !req_write && !req_any;

  always_comb begin
    phase_n  = phase;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase)
      PH_IDLE: begin
        if (accept && req_any) begin
          tmr_load = 1'b1;
          if (req_write) begin
            phase_n = PH_WSETUP;
            tmr_val = CNT_W'(T_SETUP - 1);
          end else begin
            phase_n = PH_RACCESS;
            tmr_val = CNT_W'(T_READ - 1);
          end
        end
      end
      PH_WSETUP: begin
        if (tmr_done) begin
          phase_n  = PH_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_PULSE - 1);
        end
      end
      PH_WPULSE: begin
        if (tmr_done) begin
          phase_n  = PH_WHOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_HOLD - 1);
        end
      end
      PH_WHOLD:   if (tmr_done) phase_n = PH_IDLE;
      PH_RACCESS: if (tmr_done) phase_n = PH_IDLE;
      default:    phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      ready      <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      bits_q     <= '0;
    end else begin
      phase     <= phase_n;
      ready     <= (phase_n == PH_IDLE);
      mem_ce_n  <= (phase_n == PH_IDLE);
      mem_we_n  <= (phase_n != PH_WPULSE);
      mem_oe_n  <= (phase_n != PH_RACCESS);
      mem_dq_oe <= (phase_n == PH_WPULSE) ||
                   ((phase == PH_WPULSE) && (phase_n == PH_WHOLD));
      if (start) begin
        mem_addr   <= req_addr;
        mem_be_n   <= req_be_n;
        mem_dq_out <= req_wdata;
        bits_q     <= req_bits;
      end else if (phase_n == PH_IDLE) begin
        mem_be_n <= '1;
      end
      rsp_valid <= capture || empty_rd;
      if (capture)
        rsp_rdata <= mem_dq_in & bits_q;
      else if (empty_rd)
        rsp_rdata <= '0;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int LANE_W  = 8,
  parameter int T_SETUP = 1,
  parameter int T_PULSE = 2,
  parameter int T_HOLD  = 1,
  parameter int T_READ  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic [1:0]          req_mask,
  output logic                rsp_valid,
  output logic [2*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic                mem_ub_n,
  output logic                mem_lb_n,
  output logic [2*LANE_W-1:0] mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [2*LANE_W-1:0] mem_dq_in
);

  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;
  localparam int MAXT   = max4(T_SETUP, T_PULSE, T_HOLD, T_READ);
  localparam int CNT_W  = (MAXT < 2) ? 1 : $clog2(MAXT);

  logic [LANES-1:0]  dec_be_n;
  logic [DATA_W-1:0] dec_bits;
  logic              dec_any;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_done;
  logic [LANES-1:0]  be_n;

  sram_lane_decode #(.LANES(LANES), .LANE_W(LANE_W)) u_dec (
    .mask     (req_mask),
    .be_n     (dec_be_n),
    .bit_mask (dec_bits),
    .any      (dec_any)
  );

  sram_phase_timer #(.W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_seq_fsm #(
    .ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_READ(T_READ)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be_n   (dec_be_n),
    .req_bits   (dec_bits),
    .req_any    (dec_any),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .ready      (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_be_n   (be_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  assign mem_ub_n = be_n[1];
  assign mem_lb_n = be_n[0];

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic              mem_dq_oe
);

  // R1: idle means standby with drivers off
  a_r1_idle_standby: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_ub_n && mem_lb_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R2: strobe only inside an enabled access with a lane selected
  a_r2_strobe_inside_access: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && !(mem_ub_n && mem_lb_n)));

  // R3: address and lanes hold while the strobe stays low
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n)));

  // R4: output enable is off during any write activity
  a_r4_oe_off_in_write: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

  // R5: drivers are on when the strobe falls
  a_r5_drive_at_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> mem_dq_oe);

  // R5: drivers released one cycle after the strobe rises
  a_r5_release_after: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |=> !mem_dq_oe);

  // R6: output enable only during a read access
  a_r6_oe_read_only: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

  // R7: chip enable never goes low without a lane
  a_r7_lane_on_access: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !(mem_ub_n && mem_lb_n));

  // R8: busy while the memory is enabled
  a_r8_busy_in_access: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !req_ready);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_ub_n  (mem_ub_n),
  .mem_lb_n  (mem_lb_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int T_SETUP = 1;
  localparam int T_PULSE = 2;
  localparam int T_HOLD  = 1;
  localparam int T_READ  = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl #(.T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_READ(T_READ))
  u_sram_lane_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_bits(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // memory model, driven only by the pins
  logic [15:0] mem_model [1024];
  logic [15:0] exp_mem   [1024];
  logic [15:0] rd_word;

  initial for (int i = 0; i < 1024; i++) begin mem_model[i] = '0; exp_mem[i] = '0; end

  always_comb begin
    rd_word   = mem_model[mem_addr[9:0]];
    mem_dq_in = 16'hDEAD;
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in = {mem_ub_n ? 8'hA5 : rd_word[15:8], mem_lb_n ? 8'h5A : rd_word[7:0]};
  end

  always @(posedge mem_we_n) begin
    if (!rst && mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) begin
      if (!mem_ub_n) mem_model[mem_addr[9:0]][15:8] = mem_dq_out[15:8];
      if (!mem_lb_n) mem_model[mem_addr[9:0]][7:0]  = mem_dq_out[7:0];
    end
  end

  // request context seen by the monitor
  logic        cur_wr;
  logic [16:0] cur_addr;
  logic [15:0] cur_wdata;
  logic [1:0]  cur_mask;

  // pin monitor
  int acc_cnt = 0;
  int idle_bad = 0;
  bit ce_prev = 1;
  int m_setup, m_pulse, m_hold;
  bit m_stab, m_oe, m_dq, m_rdy, m_seen, m_wr;
  logic [16:0] m_addr, m_a;
  logic [15:0] m_d;
  logic [1:0]  m_be, m_m;

  always @(negedge clk) begin
    if (rst) begin
      ce_prev = 1;
    end else begin
      if (!mem_ce_n) begin
        if (ce_prev) begin
          acc_cnt++;
          m_setup = 0; m_pulse = 0; m_hold = 0;
          m_stab = 0; m_oe = 0; m_dq = 0; m_rdy = 0; m_seen = 0;
          m_addr = mem_addr; m_be = {mem_ub_n, mem_lb_n};
          m_wr = cur_wr; m_a = cur_addr; m_d = cur_wdata; m_m = cur_mask;
        end
        if (mem_addr != m_addr || {mem_ub_n, mem_lb_n} != m_be) m_stab = 1;
        if (req_ready) m_rdy = 1;
        if (!mem_we_n) begin
          m_pulse++; m_seen = 1;
          if (!mem_dq_oe || mem_dq_out != m_d) m_dq = 1;
        end else if (!m_seen) begin
          m_setup++;
          if (m_wr && mem_dq_oe) m_dq = 1;
          if (!m_wr && mem_oe_n) m_oe = 1;
        end else begin
          m_hold++;
          if (mem_dq_oe != (m_hold == 1)) m_dq = 1;
          if (mem_dq_oe && mem_dq_out != m_d) m_dq = 1;
        end
        if (m_wr && !mem_oe_n) m_oe = 1;
      end else begin
        if (!ce_prev) begin
          chk(m_addr == m_a, "R2 address", int'(m_addr), int'(m_a));
          chk(m_be == ~m_m, "R2 lane enables", int'(m_be), int'(~m_m));
          chk(!m_stab, "R3 stability", int'(m_stab), 0);
          chk(!m_rdy, "R8 ready low in access", int'(m_rdy), 0);
          if (m_wr) begin
            chk(m_setup == T_SETUP, "R2 setup cycles", m_setup, T_SETUP);
            chk(m_pulse == T_PULSE, "R2 strobe cycles", m_pulse, T_PULSE);
            chk(m_hold == T_HOLD, "R2 hold cycles", m_hold, T_HOLD);
            chk(!m_oe, "R4 oe high in write", int'(m_oe), 0);
            chk(!m_dq, "R5 driver window", int'(m_dq), 0);
          end else begin
            chk(m_setup == T_READ, "R6 read cycles", m_setup, T_READ);
            chk(m_pulse == 0, "R6 no strobe in read", m_pulse, 0);
            chk(!m_oe, "R6 oe low in read", int'(m_oe), 0);
          end
        end
        if (req_ready && !(mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe))
          idle_bad++;
      end
      ce_prev = mem_ce_n;
    end
  end

  task automatic issue(input logic wr, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    int lat;
    logic [15:0] exp;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    cur_wr = wr; cur_addr = a; cur_wdata = d; cur_mask = m;
    exp = exp_mem[a[9:0]] & lane_bits(m);
    if (wr) exp_mem[a[9:0]] = (exp_mem[a[9:0]] & ~lane_bits(m)) | (d & lane_bits(m));
    @(negedge clk);
    req_valid = 0;
    if (m == 2'b00) chk(req_ready, "R7 ready stays high", int'(req_ready), 1);
    if (!wr) begin
      lat = 1;
      while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
      if (m == 2'b00) begin
        chk(lat == 1, "R7 empty read latency", lat, 1);
        chk(rsp_rdata == 16'h0, "R7 empty read data", int'(rsp_rdata), 0);
      end else begin
        chk(lat == T_READ + 1, "R6 read latency", lat, T_READ + 1);
        chk(rsp_rdata == exp, "R9 read data", int'(rsp_rdata), int'(exp));
      end
      @(negedge clk);
      chk(!rsp_valid, "R6 single valid pulse", int'(rsp_valid), 0);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    logic [16:0] a;
    void'($urandom(32'h5EED));
    cur_wr = 0; cur_addr = '0; cur_wdata = '0; cur_mask = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe,
        "R1 reset pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 6'b111110);
    chk(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
    rst = 0;

    // directed: full word, lane-only writes and reads
    issue(1, 17'h1_0003, 16'h1234, 2'b11);
    issue(0, 17'h1_0003, 16'h0, 2'b11);
    issue(1, 17'h1_0003, 16'hABCD, 2'b10);   // R9 upper lane only
    issue(0, 17'h1_0003, 16'h0, 2'b11);
    issue(1, 17'h1_0003, 16'h77EE, 2'b01);   // R9 lower lane only
    issue(0, 17'h1_0003, 16'h0, 2'b10);      // R6 lower lane zeroed
    issue(0, 17'h1_0003, 16'h0, 2'b01);      // R6 upper lane zeroed
    // back-to-back writes at different addresses
    issue(1, 17'h0_0005, 16'h5555, 2'b11);
    issue(1, 17'h0_0006, 16'hAAAA, 2'b11);
    issue(0, 17'h0_0005, 16'h0, 2'b11);
    issue(0, 17'h0_0006, 16'h0, 2'b11);

    // R7: empty masks leave the memory alone
    repeat (3) @(negedge clk);
    c0 = acc_cnt;
    issue(1, 17'h0_0005, 16'hFFFF, 2'b00);
    issue(0, 17'h0_0005, 16'h0, 2'b00);
    repeat (3) @(negedge clk);
    chk(acc_cnt == c0, "R7 no access for empty mask", acc_cnt - c0, 0);
    issue(0, 17'h0_0005, 16'h0, 2'b11);

    // R8: request held while busy is not taken
    c0 = acc_cnt;
    issue(1, 17'h0_0009, 16'h9999, 2'b11);
    req_valid = 1; req_write = 1; req_addr = 17'h0_000A; req_wdata = 16'hBEEF; req_mask = 2'b11;
    @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    repeat (6) @(negedge clk);
    chk(acc_cnt == c0 + 1, "R8 busy request ignored", acc_cnt - c0, 1);
    issue(0, 17'h0_000A, 16'h0, 2'b11);
    issue(0, 17'h0_0009, 16'h0, 2'b11);

    // constrained random mix over a few words
    for (int k = 0; k < 300; k++) begin
      a = {7'($urandom), 6'd0, 4'($urandom)};
      issue(1'($urandom), a, 16'($urandom), 2'($urandom));
    end
    for (int k = 0; k < 16; k++) issue(0, 17'(k), 16'h0, 2'b11);

    repeat (4) @(negedge clk);
    chk(idle_bad == 0, "R1 idle pins", idle_bad, 0);
    done = 1;
    summary();
    $finish;
  end

endmodule